// File: doc/BRIEF.md
# DMA Bus Ownership Arbiter

This block decides which of several device slots may drive the shared memory bus for direct memory access. When the bus is free, any slot may raise its request line. The arbiter picks exactly one requester and raises a bus-busy flag. While that flag is set, no other slot can take the bus. The owner keeps the bus for as long as it holds its request. When it lets go, the flag drops and the bus is free again.

While a slot owns the bus, one 32-bit word of its data moves onto the bus per device tick. The device tick is a one-cycle enable taken from the system clock through a divider that software can set. For a 100 kHz device rate, the divider is set to the system clock rate divided by 100 kHz, minus one. Each word is captured on the falling clock edge. Processor accesses use the rising edge, so the two never need contention logic.

Top module: `dma_bus_arbiter`

## Requirements
- R1: At most one `grant` bit is ever set, and `bus_busy` is high exactly when a `grant` bit is set.
- R2: If `bus_busy` is low and some `req` bits are set at a rising edge, then after that edge `bus_busy` is high and the grant goes to the lowest set index. Bit i of `grant` belongs to slot i.
- R3: While the owner keeps its `req` bit high, the grant does not move, even when lower-index slots request.
- R4: If the owner's `req` bit is low at a rising edge, `grant` and `bus_busy` clear on that edge. A new owner can be granted no earlier than the following edge.
- R5: The device tick fires once every `tick_div`+1 system cycles. While the bus is owned, `xfer_stb` is high for exactly one cycle per tick, and it is never high while `bus_busy` is low.
- R6: `xfer_stb` and `bus_data` change only on the falling edge of `clk`. During a strobe, `bus_data` equals the owner's word `dev_data[32*i +: 32]` and `xfer_slot` equals the owner's index i.
- R7: With no owner, no transfer strobes appear. Requests from slots other than the owner do not change the grant.
- R8: While `rst_n` is low at the clock edges, `grant`, `bus_busy` and `xfer_stb` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Arbitration uses the rising edge; transfers use the falling edge. |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_div | input | DIV_W | Device tick period, in system cycles, minus one |
| req | input | NUM_SLOTS | DMA request, one bit per slot |
| dev_data | input | NUM_SLOTS*DATA_W | Outgoing data word of each slot, packed by slot index |
| grant | output | NUM_SLOTS | One-hot bus ownership |
| bus_busy | output | 1 | Bus is owned by a slot |
| xfer_stb | output | 1 | A word is being moved in this tick |
| xfer_slot | output | SLOT_W | Index of the current owner |
| bus_data | output | DATA_W | Word moved on the bus |

## Verification
The bench uses a four-slot setup. It tries every one of the 16 request patterns starting from an idle bus. This shows that lowest-index selection works for every combination of competing slots and that an empty pattern grants nothing. A separate sequence adds lower-index requests while a high slot owns the bus, and then removes the owner's request. This separates holding the grant, the release cycle with no owner, and re-arbitration one edge later. Each divider value from 0 to 3 is run over a window that is a whole number of periods, so the exact strobe count can be computed. Sampling before and after each falling edge shows which edge the transfer uses, and an idle window checks that no strobes appear without an owner.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 16,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DIV_W-1:0]            tick_div,
  input  logic [NUM_SLOTS-1:0]        req,
  input  logic [NUM_SLOTS*DATA_W-1:0] dev_data,
  output logic [NUM_SLOTS-1:0]        grant,
  output logic                        bus_busy,
  output logic                        xfer_stb,
  output logic [SLOT_W-1:0]           xfer_slot,
  output logic [DATA_W-1:0]           bus_data
);

  logic [DIV_W-1:0]  cnt;
  logic              tick;
  logic              busy;
  logic [SLOT_W-1:0] owner;
  logic [SLOT_W-1:0] pick_idx;
  logic              owner_req;

  always_comb begin
    pick_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (req[i]) pick_idx = SLOT_W'(i);
  end

  assign owner_req = req[owner];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tick  <= 1'b0;
      busy  <= 1'b0;
      owner <= '0;
    end else begin
      if (cnt >= tick_div) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
      if (busy) begin
        if (!owner_req) busy <= 1'b0;
      end else if (|req) begin
        busy  <= 1'b1;
        owner <= pick_idx;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      xfer_stb <= 1'b0;
      bus_data <= '0;
    end else begin
      xfer_stb <= tick & busy;
      if (tick && busy) bus_data <= dev_data[owner*DATA_W +: DATA_W];
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_grant
    assign grant[g] = busy && (owner == SLOT_W'(g));
  end

  assign bus_busy  = busy;
  assign xfer_slot = owner;

  p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && req[0]) |=> (bus_busy && grant[0]));

  p_idle_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && |req) |=> bus_busy);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && owner_req) |=> (bus_busy && $stable(grant)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !owner_req) |=> (!bus_busy && grant == '0));

  p_strobe_needs_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> bus_busy);

  p_strobe_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && tick_div != '0) |=> !xfer_stb);

endmodule

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] tick_div = '0;
  logic [N-1:0]  req = '0;
  logic [N*DW-1:0] dev_data;
  logic [N-1:0]  grant;
  logic          bus_busy;
  logic          xfer_stb;
  logic [1:0]    xfer_slot;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter #(.NUM_SLOTS(N), .DATA_W(DW), .DIV_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .req(req),
    .dev_data(dev_data), .grant(grant), .bus_busy(bus_busy),
    .xfer_stb(xfer_stb), .xfer_slot(xfer_slot), .bus_data(bus_data));

  function automatic logic [DW-1:0] word_of(int s);
    return 32'hA5000000 + 32'(s) * 32'h00010203 + 32'h7;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    finish_run();
  end

  initial begin
    for (int s = 0; s < N; s++) dev_data[s*DW +: DW] = word_of(s);
    repeat (4) step();
    chk(grant == '0, "R8 reset grant", grant, 0);
    chk(!bus_busy, "R8 reset busy", bus_busy, 0);
    chk(!xfer_stb, "R8 reset strobe", xfer_stb, 0);
    rst_n = 1'b1;
    step();

    // R2/R1: every request pattern from idle
    for (int p = 0; p < 16; p++) begin
      logic [N-1:0] pv;
      logic [N-1:0] exp_g;
      pv = N'(p);
      exp_g = pv & (~pv + 1'b1);
      req = pv;
      step();
      chk(grant == exp_g, "R2 lowest index granted", grant, exp_g);
      chk(bus_busy == (p != 0), "R1 busy matches grant", bus_busy, p != 0);
      req = '0;
      step();
      chk(grant == '0 && !bus_busy, "R4 release clears", {bus_busy, grant}, 0);
    end

    // R3/R7: no pre-emption by lower slots
    req = 4'b1000;
    step();
    chk(grant == 4'b1000, "R2 single requester", grant, 4'b1000);
    req = 4'b1111;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(grant == 4'b1000, "R3 owner keeps grant", grant, 4'b1000);
      chk(xfer_slot == 2'd3, "R7 others ignored slot", xfer_slot, 3);
    end
    req = 4'b0111;
    step();
    chk(!bus_busy && grant == '0, "R4 dead cycle after release", {bus_busy, grant}, 0);
    step();
    chk(grant == 4'b0001, "R4 rearbitration next edge", grant, 4'b0001);
    req = '0;
    step();
    step();

    // R5/R6/R7: pacing and falling-edge transfer
    for (int d = 0; d < 4; d++) begin
      int seen;
      int rises;
      int bad_data;
      tick_div = VW'(d);
      req = N'(1) << d;
      repeat (10) step();
      chk(grant == (N'(1) << d), "R2 pacing owner", grant, N'(1) << d);
      seen = 0;
      rises = 0;
      bad_data = 0;
      for (int c = 0; c < 5 * (d + 1); c++) begin
        logic a;
        logic b;
        step();
        a = xfer_stb;
        if (a) begin
          seen++;
          if (bus_data != word_of(d) || xfer_slot != 2'(d)) bad_data++;
        end
        #2.5;
        b = xfer_stb;
        if (!a && b) rises++;
      end
      chk(seen == 5, "R5 one strobe per tick", seen, 5);
      chk(bad_data == 0, "R6 owner word and slot", bad_data, 0);
      if (d > 0) chk(rises == 5, "R6 strobe starts at falling edge", rises, 5);
      req = '0;
      repeat (3) step();
      seen = 0;
      for (int c = 0; c < 8; c++) begin
        step();
        if (xfer_stb) seen++;
      end
      chk(seen == 0, "R7 no strobes while idle", seen, 0);
      chk(!bus_busy, "R5 idle busy low", bus_busy, 0);
    end

    finish_run();
  end
endmodule